// File: doc/BRIEF.md
# DS3 Nibble Payload Strobe Interface

This block is the transmit-side payload entry point of a DS3 framer that runs as frame master on local timing with a 4-bit parallel payload port. One line-rate bit clock (nominally 44.736 MHz) drives free-running frame counters. The counters lay out an outbound frame of 7 subframes, each of 8 blocks. Every block is 85 clock cycles long: one overhead-bit slot followed by 84 payload cycles, which carry 21 nibbles. The frame timing starts from reset and is not aligned to any external signal.

From that timing the block sends the terminal equipment a gapped, single-cycle nibble request strobe. Only payload nibbles are requested, so strobes are normally 4 cycles apart and 5 cycles apart where a block's overhead slot falls between them. A frame pulse marks the request for the final nibble of each frame. The nibble input is captured on the third rising clock edge after each strobe. It is handed to the downstream frame assembler as a valid-qualified word tagged with its subframe and block. A separate one-cycle marker flags every overhead-bit slot, so the assembler knows where to insert its own bits.

Top module: `ds3_nib_payload_if`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge. After the first edge with `rst` low, `oh_slot_o` is 1, which marks the overhead slot of block 0 of subframe 0.
- R2: The frame is 4760 clock cycles long. Consecutive `frame_o` pulses are exactly 4760 cycles apart.
- R3: Let t be the frame cycle index, where t = 0 for the first edge after reset release, and let p = t mod 85. `oh_slot_o` is 1 exactly when p = 0. `nib_strobe_o` is a one-cycle pulse that is 1 exactly when p mod 4 = 1, which gives p = 1, 5, ..., 81.
- R4: Consecutive strobes are 4 cycles apart within a block and 5 cycles apart across a block's overhead slot. No other spacing occurs.
- R5: Each frame holds exactly 1176 strobes. `frame_o` is 1 only together with the last strobe of the frame (subframe 6, block 7, p = 81, t = 4756).
- R6: For a strobe seen after edge n, `pay_valid_o` is 1 for exactly one cycle after edge n+3. At all other times it is 0.
- R7: With a valid word, `pay_sf_o` = floor(t/680) and `pay_blk_o` = floor(t/85) mod 8, where t is the frame cycle of the strobe that requested the word.
- R8: `pay_nib_o` equals the value `nib_i` held at edge n+3 (the third edge after the strobe). Values of `nib_i` at any other edge have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate bit clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_i | input | 4 | Payload nibble from terminal equipment |
| nib_strobe_o | output | 1 | One-cycle payload nibble request |
| frame_o | output | 1 | Marks the request for the frame's last nibble |
| oh_slot_o | output | 1 | One-cycle marker of each overhead-bit slot |
| pay_valid_o | output | 1 | Captured nibble valid |
| pay_nib_o | output | 4 | Captured payload nibble |
| pay_sf_o | output | 3 | Subframe of the captured nibble |
| pay_blk_o | output | 3 | Block of the captured nibble |

## Verification
The bench drives each requested nibble only in the single cycle before the third edge after its strobe, and drives its complement at the edge after. A design that sampled one edge early or late would return inverted data rather than pass by luck. Strobe spacing is checked at every block boundary, including the one between subframe 6 and subframe 0 of the next frame. An off-by-one in the block length would break the 4/5 pattern there, and a misplaced wrap would break the 1176-strobe count and the 4760-cycle frame length. A reset applied in the middle of a frame must return the counters to the first overhead slot. A design that only cleared its outputs would misplace every later strobe.

// File: rtl/ds3_nib_pkg.sv
package ds3_nib_pkg;

  // Default frame geometry (7 x 8 blocks of 1 overhead + 21 nibbles)
  localparam int DEF_SUBFRAMES  = 7;
  localparam int DEF_BLOCKS     = 8;
  localparam int DEF_NIBS_BLK   = 21;
  localparam int DEF_NIB_W      = 4;
  localparam int DEF_SAMPLE_DLY = 3;

  // What the current bit-clock cycle carries
  typedef enum logic [1:0] {
    SLOT_OH   = 2'd0,  // overhead bit slot
    SLOT_REQ  = 2'd1,  // first cycle of a payload nibble: request it
    SLOT_HOLD = 2'd2   // remaining cycles of a payload nibble
  } slot_e;

endpackage

// File: rtl/ds3_frame_timer.sv
module ds3_frame_timer
  import ds3_nib_pkg::*;
#(
  parameter int SUBFRAMES = DEF_SUBFRAMES,
  parameter int BLOCKS    = DEF_BLOCKS,
  parameter int NIBS_BLK  = DEF_NIBS_BLK,
  parameter int NIB_W     = DEF_NIB_W,
  localparam int SF_W     = (SUBFRAMES > 1) ? $clog2(SUBFRAMES) : 1,
  localparam int BLK_W    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int NIDX_W   = (NIBS_BLK > 1) ? $clog2(NIBS_BLK) : 1,
  localparam int PH_W     = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output slot_e            slot_o,
  output logic             last_nib_o,
  output logic [SF_W-1:0]  sf_o,
  output logic [BLK_W-1:0] blk_o
);

  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(NIB_W - 1);
  localparam logic [NIDX_W-1:0] NIDX_LAST = NIDX_W'(NIBS_BLK - 1);
  localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(BLOCKS - 1);
  localparam logic [SF_W-1:0]   SF_LAST   = SF_W'(SUBFRAMES - 1);

  logic              oh_q;
  logic [PH_W-1:0]   ph_q;
  logic [NIDX_W-1:0] nidx_q;
  logic [BLK_W-1:0]  blk_q;
  logic [SF_W-1:0]   sf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_q   <= 1'b1;
      ph_q   <= '0;
      nidx_q <= '0;
      blk_q  <= '0;
      sf_q   <= '0;
    end else if (oh_q) begin
      oh_q   <= 1'b0;
      ph_q   <= '0;
      nidx_q <= '0;
    end else if (ph_q != PH_LAST) begin
      ph_q <= ph_q + 1'b1;
    end else begin
      ph_q <= '0;
      if (nidx_q != NIDX_LAST) begin
        nidx_q <= nidx_q + 1'b1;
      end else begin
        nidx_q <= '0;
        oh_q   <= 1'b1;
        if (blk_q != BLK_LAST) begin
          blk_q <= blk_q + 1'b1;
        end else begin
          blk_q <= '0;
          sf_q  <= (sf_q != SF_LAST) ? sf_q + 1'b1 : '0;
        end
      end
    end
  end

  always_comb begin
    if (oh_q)              slot_o = SLOT_OH;
    else if (ph_q == '0)   slot_o = SLOT_REQ;
    else                   slot_o = SLOT_HOLD;
  end

  assign last_nib_o = (nidx_q == NIDX_LAST) && (blk_q == BLK_LAST) && (sf_q == SF_LAST);
  assign sf_o       = sf_q;
  assign blk_o      = blk_q;

endmodule

// File: rtl/ds3_strobe_gen.sv
module ds3_strobe_gen
  import ds3_nib_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_e            slot_i,
  input  logic             last_nib_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             strobe_o,
  output logic             frame_o,
  output logic             oh_o,
  output logic [POS_W-1:0] pos_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= 1'b0;
      frame_o  <= 1'b0;
      oh_o     <= 1'b0;
      pos_o    <= '0;
    end else begin
      strobe_o <= (slot_i == SLOT_REQ);
      frame_o  <= (slot_i == SLOT_REQ) && last_nib_i;
      oh_o     <= (slot_i == SLOT_OH);
      if (slot_i == SLOT_REQ) pos_o <= pos_i;
    end
  end

endmodule

// File: rtl/ds3_nib_sampler.sv
module ds3_nib_sampler #(
  parameter int NIB_W      = 4,
  parameter int POS_W      = 6,
  parameter int SAMPLE_DLY = 3,
  localparam int STAGES    = SAMPLE_DLY - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             valid_o,
  output logic [NIB_W-1:0] nib_o,
  output logic [POS_W-1:0] pos_o
);

  logic             take;
  logic [POS_W-1:0] take_pos;

  generate
    if (STAGES == 0) begin : g_direct
      assign take     = strobe_i;
      assign take_pos = pos_i;
    end else begin : g_delay
      logic [STAGES-1:0] vld_q;
      logic [POS_W-1:0]  pos_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            vld_q[s] <= 1'b0;
            pos_q[s] <= '0;
          end else if (s == 0) begin
            vld_q[s] <= strobe_i;
            pos_q[s] <= pos_i;
          end else begin
            vld_q[s] <= vld_q[s-1];
            pos_q[s] <= pos_q[s-1];
          end
        end
      end
      assign take     = vld_q[STAGES-1];
      assign take_pos = pos_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      nib_o   <= '0;
      pos_o   <= '0;
    end else begin
      valid_o <= take;
      if (take) begin
        nib_o <= nib_i;
        pos_o <= take_pos;
      end
    end
  end

endmodule

// File: rtl/ds3_nib_payload_if.sv
module ds3_nib_payload_if
  import ds3_nib_pkg::*;
#(
  parameter int SUBFRAMES  = DEF_SUBFRAMES,
  parameter int BLOCKS     = DEF_BLOCKS,
  parameter int NIBS_BLK   = DEF_NIBS_BLK,
  parameter int NIB_W      = DEF_NIB_W,
  parameter int SAMPLE_DLY = DEF_SAMPLE_DLY,
  localparam int SF_W      = (SUBFRAMES > 1) ? $clog2(SUBFRAMES) : 1,
  localparam int BLK_W     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_i,
  output logic             nib_strobe_o,
  output logic             frame_o,
  output logic             oh_slot_o,
  output logic             pay_valid_o,
  output logic [NIB_W-1:0] pay_nib_o,
  output logic [SF_W-1:0]  pay_sf_o,
  output logic [BLK_W-1:0] pay_blk_o
);

  localparam int POS_W = SF_W + BLK_W;

  slot_e            slot;
  logic             last_nib;
  logic [SF_W-1:0]  tm_sf;
  logic [BLK_W-1:0] tm_blk;
  logic [POS_W-1:0] req_pos;
  logic [POS_W-1:0] out_pos;

  ds3_frame_timer #(
    .SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .NIBS_BLK(NIBS_BLK), .NIB_W(NIB_W)
  ) u_timer (
    .clk(clk), .rst(rst), .slot_o(slot), .last_nib_o(last_nib),
    .sf_o(tm_sf), .blk_o(tm_blk)
  );

  ds3_strobe_gen #(.POS_W(POS_W)) u_strobe (
    .clk(clk), .rst(rst), .slot_i(slot), .last_nib_i(last_nib),
    .pos_i({tm_sf, tm_blk}), .strobe_o(nib_strobe_o), .frame_o(frame_o),
    .oh_o(oh_slot_o), .pos_o(req_pos)
  );

  ds3_nib_sampler #(
    .NIB_W(NIB_W), .POS_W(POS_W), .SAMPLE_DLY(SAMPLE_DLY)
  ) u_sampler (
    .clk(clk), .rst(rst), .strobe_i(nib_strobe_o), .pos_i(req_pos),
    .nib_i(nib_i), .valid_o(pay_valid_o), .nib_o(pay_nib_o), .pos_o(out_pos)
  );

  assign pay_sf_o  = out_pos[POS_W-1:BLK_W];
  assign pay_blk_o = out_pos[BLK_W-1:0];

endmodule

// File: rtl/ds3_nib_payload_chk.sv
module ds3_nib_payload_chk #(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  parameter int NIBS_BLK  = 21,
  parameter int NIB_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NIB_W-1:0] nib_i,
  input logic             nib_strobe_o,
  input logic             frame_o,
  input logic             oh_slot_o,
  input logic             pay_valid_o,
  input logic [NIB_W-1:0] pay_nib_o
);

  localparam int TOTAL = SUBFRAMES * BLOCKS * NIBS_BLK;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int GAP_W = $clog2(NIB_W + 3);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic [CNT_W-1:0] nibs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      nibs_q <= '0;
    end else begin
      if (nib_strobe_o) begin
        gap_q  <= GAP_W'(1);
        seen_q <= 1'b1;
        nibs_q <= frame_o ? '0 : nibs_q + 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R3
  oh_then_req_chk: assert property (@(posedge clk) disable iff (rst)
    oh_slot_o |=> nib_strobe_o);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    nib_strobe_o |=> !nib_strobe_o);

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (nib_strobe_o && seen_q) |-> (gap_q == GAP_W'(NIB_W) || gap_q == GAP_W'(NIB_W + 1)));

  // R5
  frame_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> nib_strobe_o);

  // R5
  nibs_per_frame_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> (nibs_q == CNT_W'(TOTAL - 1)));

  // R6
  valid_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid_o |-> $past(nib_strobe_o, 3));

  // R8
  data_capture_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid_o |-> (pay_nib_o == $past(nib_i)));

endmodule

bind ds3_nib_payload_if ds3_nib_payload_chk #(
  .SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .NIBS_BLK(NIBS_BLK), .NIB_W(NIB_W)
) u_chk (
  .clk(clk), .rst(rst), .nib_i(nib_i), .nib_strobe_o(nib_strobe_o),
  .frame_o(frame_o), .oh_slot_o(oh_slot_o), .pay_valid_o(pay_valid_o),
  .pay_nib_o(pay_nib_o)
);

// File: tb/sim_ds3_nib_payload_if.sv
`timescale 1ns/1ps
module sim_ds3_nib_payload_if;

  localparam int FRAME_LEN = 4760;
  localparam int BLK_LEN   = 85;
  localparam int SF_LEN    = 680;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nib_i = 4'h0;
  logic       nib_strobe_o, frame_o, oh_slot_o, pay_valid_o;
  logic [3:0] pay_nib_o;
  logic [2:0] pay_sf_o, pay_blk_o;

  always #2 clk = ~clk;

  ds3_nib_payload_if u0 (
    .clk(clk), .rst(rst), .nib_i(nib_i), .nib_strobe_o(nib_strobe_o),
    .frame_o(frame_o), .oh_slot_o(oh_slot_o), .pay_valid_o(pay_valid_o),
    .pay_nib_o(pay_nib_o), .pay_sf_o(pay_sf_o), .pay_blk_o(pay_blk_o)
  );

  typedef struct { int due; int nib; int sf; int blk; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int n, last_stb, last_frm, stb_since, drive_at, drive_val, seq;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    n = 0; q.delete(); last_stb = -1; last_frm = -1;
    stb_since = 0; drive_at = -10;
  endtask

  task automatic reset_checks(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      nib_i = 4'(i * 5 + 3);
      chk("R1 strobe in reset", nib_strobe_o, 0);
      chk("R1 frame in reset", frame_o, 0);
      chk("R1 overhead in reset", oh_slot_o, 0);
      chk("R1 valid in reset", pay_valid_o, 0);
    end
  endtask

  task automatic next_nib(int mode, output int v);
    if (mode == 0) begin
      v = seq % 16; seq++;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = int'(lfsr[3:0]);
    end
  endtask

  task automatic run(int cycles, int mode);
    for (int i = 0; i < cycles; i++) begin
      int t, p, v;
      bit e_stb, e_oh, e_frm;
      @(negedge clk);
      n++;
      t = (n - 1) % FRAME_LEN;
      p = t % BLK_LEN;
      e_stb = (p % 4 == 1);
      e_oh  = (p == 0);
      e_frm = e_stb && (t == FRAME_LEN - 4);
      if (n == 1) chk("R1 first overhead slot", oh_slot_o, 1);
      chk("R3 strobe position", nib_strobe_o, e_stb);
      chk("R3 overhead marker", oh_slot_o, e_oh);
      chk("R5 frame pulse", frame_o, e_frm);
      if (q.size() > 0 && q[0].due == n) begin
        chk("R6 valid", pay_valid_o, 1);
        chk("R8 data", pay_nib_o, q[0].nib);
        chk("R7 subframe", pay_sf_o, q[0].sf);
        chk("R7 block", pay_blk_o, q[0].blk);
        void'(q.pop_front());
      end else begin
        chk("R6 no valid", pay_valid_o, 0);
      end
      if (nib_strobe_o === 1'b1) begin
        if (last_stb >= 0) chk("R4 strobe gap", n - last_stb, (p == 1) ? 5 : 4);
        last_stb = n;
        stb_since++;
      end
      if (frame_o === 1'b1) begin
        chk("R5 strobes per frame", stb_since, 1176);
        if (last_frm >= 0) chk("R2 frame length", n - last_frm, FRAME_LEN);
        last_frm = n;
        stb_since = 0;
      end
      if (e_stb) begin
        next_nib(mode, v);
        q.push_back('{n + 3, v, t / SF_LEN, (t / BLK_LEN) % 8});
        drive_at  = n + 2;
        drive_val = v;
      end
      // R8: the nibble is valid only for the third edge after the strobe
      if (n == drive_at) nib_i = 4'(drive_val);
      else if (n == drive_at + 1) nib_i = 4'(drive_val) ^ 4'hF;
    end
  endtask

  initial begin
    seq = 0;
    restart();
    rst = 1'b1;
    reset_checks(4);
    rst = 1'b0;
    run(2 * FRAME_LEN + 1000, 0);
    @(negedge clk);
    rst = 1'b1;
    reset_checks(3);
    restart();
    rst = 1'b0;
    run(FRAME_LEN + 300, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule